// File: doc/BRIEF.md
# Context-Switching Scratchpad Register File

This block holds sixteen 16-bit general registers and the small amount of state that decides what they mean at any moment. A 4-bit program selector picks which register acts as the program counter. A 4-bit data selector picks which register acts as the data pointer. An 8-bit save register keeps a copy of both selectors, and a single enable bit gates interrupts. No register is the program counter or stack pointer by fixed wiring. A context switch rewrites the two selectors. It does not copy register contents anywhere.

An instruction sequencer presents one opcode per cycle together with the accumulator byte. The block performs the register-file side of that opcode in the same clock edge: increment, decrement, byte put and byte get, selector loads, return, disable, mark and save. It also takes interrupts. Stack bytes go through a one-byte memory port. The address, write data and strobes are combinational from the current state. Read data is expected back in the same cycle. An accepted interrupt takes priority over the opcode presented in that cycle. The `int_taken` output tells the sequencer that the opcode was not executed.

Top module: `ctx_regfile`

## Requirements
- R1: Synchronous active-low reset sets the program selector, data selector, save register and interrupt enable to 0 and register 0 to 0x0000. The other registers are not reset.
- R2: Opcode 0xAn writes `d_in` into bits 7:0 of register n, and 0xBn writes it into bits 15:8; the other byte of that register is unchanged.
- R3: Opcodes 0x8n and 0x9n drive bits 7:0 and bits 15:8 of register n on `d_out` in the same cycle, with `d_valid` high. In every other cycle `d_out` is 0x00.
- R4: Opcode 0x1n adds one to register n and 0x2n subtracts one. Both wrap modulo 2^16, so a carry or borrow crosses the byte boundary.
- R5: Opcode 0xDn loads the program selector with n, and 0xEn loads the data selector with n.
- R6: Opcode 0x60 adds one to the register named by the data selector.
- R7: Opcodes 0x70 and 0x71 assert `mem_re` with `mem_addr` equal to the data-pointer register. They load the data selector from bits 7:4 and the program selector from bits 3:0 of `mem_rdata`. They add one to the register the old data selector named. 0x70 sets the interrupt enable to 1 and 0x71 sets it to 0.
- R8: Opcode 0x79 loads the save register with {data selector, program selector}. It writes that byte to memory at register 2 (`mem_we`), copies the program selector into the data selector and subtracts one from register 2.
- R9: Opcode 0x78 writes the save register to memory at the data-pointer register. Selectors, enable and registers are unchanged.
- R10: When `int_req` is high and the enable is 1, the block raises `int_taken` in that cycle. At the edge it loads the save register with {data selector, program selector}, sets the program selector to 1 and the data selector to 2, and clears the enable. The opcode presented in that cycle has no effect.
- R11: When the enable is 0, `int_req` is ignored: `int_taken` stays low and the presented opcode executes.
- R12: `pc_out` always shows the register named by the program selector, and `dp_out` the register named by the data selector.
- R13: Any other opcode (for example 0xF4) leaves selectors, enable, save register and registers unchanged and drives no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An opcode is presented this cycle |
| op_code | input | 8 | Opcode byte |
| d_in | input | 8 | Accumulator byte for put operations |
| int_req | input | 1 | Interrupt request level |
| mem_rdata | input | 8 | Byte read back from memory, same cycle |
| d_out | output | 8 | Byte fetched by a get operation |
| d_valid | output | 1 | `d_out` carries a get result |
| int_taken | output | 1 | Interrupt accepted this cycle, opcode dropped |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_out | output | 16 | Current program-counter register |
| dp_out | output | 16 | Current data-pointer register |
| p_sel | output | 4 | Program selector |
| x_sel | output | 4 | Data selector |
| t_out | output | 8 | Save register |
| ie_out | output | 1 | Interrupt enable |

## Verification
The bench builds the block with its default parameters: stack register 2, interrupt program selector 1 and interrupt data selector 2. With these values the stack push of the mark opcode and the interrupt jump land on registers that the bench loads through the byte-put opcodes. The selectors can then be read back as {2,1} after an interrupt, and the save register shows the context that was interrupted. The vector walk covers carries and borrows across the byte boundary and full 16-bit wrap. Directed cases cover memory strobe contents, an interrupt colliding with an opcode, a masked request, and reset of register 0 after it was written.

// File: rtl/ctx_pkg.sv
// Shared types for the context-switching register file.
// Assumes the 8-bit opcode layout: high nibble selects the operation,
// low nibble names a register.
package ctx_pkg;
    localparam int SEL_W  = 4;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;
    localparam int NREGS  = 1 << SEL_W;

    typedef enum logic [3:0] {
        K_NONE, K_INC, K_DEC, K_GLO, K_GHI, K_PLO, K_PHI, K_SEP,
        K_SEX, K_IRX, K_RET, K_DIS, K_MARK, K_SAV, K_INT
    } op_kind_t;

    typedef struct packed {
        op_kind_t          kind;
        logic [SEL_W-1:0]  nib;
    } op_dec_t;
endpackage

// File: rtl/ctx_decode.sv
// Opcode classifier: maps the presented opcode (or an accepted interrupt)
// onto one operation kind plus the register nibble.
// Assumes the interrupt decision is made by the caller.
module ctx_decode
    import ctx_pkg::*;
(
    input  logic              op_valid,
    input  logic [BYTE_W-1:0] op_code,
    input  logic              accept_int,
    output op_dec_t           dec
);
    logic [SEL_W-1:0] hi;
    logic [SEL_W-1:0] lo;

    assign hi = op_code[BYTE_W-1:SEL_W];
    assign lo = op_code[SEL_W-1:0];

    // Classify: interrupt first, then the opcode groups handled here.
    always_comb begin
        dec.nib  = lo;
        dec.kind = K_NONE;
        if (accept_int) begin
            dec.kind = K_INT;
        end else if (op_valid) begin
            unique case (hi)
                4'h1: dec.kind = K_INC;
                4'h2: dec.kind = K_DEC;
                4'h8: dec.kind = K_GLO;
                4'h9: dec.kind = K_GHI;
                4'hA: dec.kind = K_PLO;
                4'hB: dec.kind = K_PHI;
                4'hD: dec.kind = K_SEP;
                4'hE: dec.kind = K_SEX;
                4'h6: dec.kind = (lo == 4'h0) ? K_IRX : K_NONE;
                4'h7: begin
                    unique case (lo)
                        4'h0:    dec.kind = K_RET;
                        4'h1:    dec.kind = K_DIS;
                        4'h8:    dec.kind = K_SAV;
                        4'h9:    dec.kind = K_MARK;
                        default: dec.kind = K_NONE;
                    endcase
                end
                default: dec.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ctx_regbank.sv
// Sixteen-entry register array with one write port and four read ports.
// Only register 0 is reset; the others keep whatever they hold.
module ctx_regbank #(
    parameter int NR  = 16,
    parameter int W   = 16,
    localparam int IW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_val,
    input  logic [IW-1:0] rd_n_idx,
    input  logic [IW-1:0] rd_p_idx,
    input  logic [IW-1:0] rd_x_idx,
    input  logic [IW-1:0] rd_s_idx,
    output logic [W-1:0]  rd_n,
    output logic [W-1:0]  rd_p,
    output logic [W-1:0]  rd_x,
    output logic [W-1:0]  rd_s
);
    logic [W-1:0] regs [NR];

    for (genvar g = 0; g < NR; g++) begin : g_reg
        logic [W-1:0] q;
        if (g == 0) begin : g_rst
            // Register 0: cleared by reset, then written like the rest.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_idx == IW'(g))
                    q <= wr_val;
            end
        end else begin : g_norst
            // Other registers: no reset, write on index match.
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IW'(g))
                    q <= wr_val;
            end
        end
        assign regs[g] = q;
    end

    assign rd_n = regs[rd_n_idx];
    assign rd_p = regs[rd_p_idx];
    assign rd_x = regs[rd_x_idx];
    assign rd_s = regs[rd_s_idx];
endmodule

// File: rtl/ctx_selectors.sv
// Program selector, data selector, save register and interrupt enable.
// Assumes at most one operation kind per cycle from the decoder.
module ctx_selectors
    import ctx_pkg::*;
#(
    parameter logic [SEL_W-1:0] INT_P_SEL = 4'd1,
    parameter logic [SEL_W-1:0] INT_X_SEL = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_dec_t           dec,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [SEL_W-1:0]  p_q,
    output logic [SEL_W-1:0]  x_q,
    output logic [BYTE_W-1:0] t_q,
    output logic              ie_q
);
    // Context state update per operation kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q  <= '0;
            x_q  <= '0;
            t_q  <= '0;
            ie_q <= 1'b0;
        end else begin
            unique case (dec.kind)
                K_INT: begin
                    t_q  <= {x_q, p_q};
                    p_q  <= INT_P_SEL;
                    x_q  <= INT_X_SEL;
                    ie_q <= 1'b0;
                end
                K_SEP: p_q <= dec.nib;
                K_SEX: x_q <= dec.nib;
                K_RET: begin
                    {x_q, p_q} <= mem_rdata;
                    ie_q       <= 1'b1;
                end
                K_DIS: begin
                    {x_q, p_q} <= mem_rdata;
                    ie_q       <= 1'b0;
                end
                K_MARK: begin
                    t_q <= {x_q, p_q};
                    x_q <= p_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctx_regfile.sv
// Top: register file with selector-based context switching.
// Executes one opcode per cycle; the memory port is combinational and the
// read byte must return in the same cycle. An accepted interrupt wins.
module ctx_regfile
    import ctx_pkg::*;
#(
    parameter logic [SEL_W-1:0] STACK_IDX = 4'd2,
    parameter logic [SEL_W-1:0] INT_P_SEL = 4'd1,
    parameter logic [SEL_W-1:0] INT_X_SEL = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [7:0]        d_in,
    input  logic              int_req,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        d_out,
    output logic              d_valid,
    output logic              int_taken,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [15:0]       pc_out,
    output logic [15:0]       dp_out,
    output logic [3:0]        p_sel,
    output logic [3:0]        x_sel,
    output logic [7:0]        t_out,
    output logic              ie_out
);
    op_dec_t           dec;
    logic [REG_W-1:0]  rd_n, rd_p, rd_x, rd_s;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_idx;
    logic [REG_W-1:0]  wr_val;

    assign int_taken = int_req & ie_out;

    ctx_decode u_dec (
        .op_valid   (op_valid),
        .op_code    (op_code),
        .accept_int (int_taken),
        .dec        (dec)
    );

    ctx_selectors #(
        .INT_P_SEL (INT_P_SEL),
        .INT_X_SEL (INT_X_SEL)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .mem_rdata (mem_rdata),
        .p_q       (p_sel),
        .x_q       (x_sel),
        .t_q       (t_out),
        .ie_q      (ie_out)
    );

    ctx_regbank #(.NR(NREGS), .W(REG_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .rd_n_idx (dec.nib),
        .rd_p_idx (p_sel),
        .rd_x_idx (x_sel),
        .rd_s_idx (STACK_IDX),
        .rd_n     (rd_n),
        .rd_p     (rd_p),
        .rd_x     (rd_x),
        .rd_s     (rd_s)
    );

    // Register write port: pick target and new value per operation.
    always_comb begin
        wr_en  = 1'b1;
        wr_idx = dec.nib;
        wr_val = rd_n;
        unique case (dec.kind)
            K_INC: wr_val = rd_n + 1'b1;
            K_DEC: wr_val = rd_n - 1'b1;
            K_PLO: wr_val = {rd_n[REG_W-1:BYTE_W], d_in};
            K_PHI: wr_val = {d_in, rd_n[BYTE_W-1:0]};
            K_IRX, K_RET, K_DIS: begin
                wr_idx = x_sel;
                wr_val = rd_x + 1'b1;
            end
            K_MARK: begin
                wr_idx = STACK_IDX;
                wr_val = rd_s - 1'b1;
            end
            default: wr_en = 1'b0;
        endcase
    end

    // Memory port: stack push, save, or selector pop.
    always_comb begin
        mem_addr  = rd_p;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        unique case (dec.kind)
            K_MARK: begin
                mem_addr  = rd_s;
                mem_wdata = {x_sel, p_sel};
                mem_we    = 1'b1;
            end
            K_SAV: begin
                mem_addr  = rd_x;
                mem_wdata = t_out;
                mem_we    = 1'b1;
            end
            K_RET, K_DIS: begin
                mem_addr = rd_x;
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end

    // Byte get path toward the accumulator.
    always_comb begin
        d_valid = 1'b0;
        d_out   = '0;
        if (dec.kind == K_GLO) begin
            d_valid = 1'b1;
            d_out   = rd_n[BYTE_W-1:0];
        end else if (dec.kind == K_GHI) begin
            d_valid = 1'b1;
            d_out   = rd_n[REG_W-1:BYTE_W];
        end
    end

    assign pc_out = rd_p;
    assign dp_out = rd_x;
endmodule

// File: rtl/ctx_regfile_chk.sv
// Property checker for ctx_regfile, attached by bind.
module ctx_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic [7:0] mem_rdata,
    input logic       int_taken,
    input logic       mem_we,
    input logic       mem_re,
    input logic [3:0] p_sel,
    input logic [3:0] x_sel,
    input logic [7:0] t_out,
    input logic       ie_out
);
    logic run_op;
    assign run_op = op_valid && !int_taken;

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (p_sel == 4'd0 && x_sel == 4'd0 && !ie_out && t_out == 8'd0));

    p_sel_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_op && op_code[7:4] == 4'hD) |=> (p_sel == $past(op_code[3:0])));

    p_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_op && op_code == 8'h70) |=> (ie_out && {x_sel, p_sel} == $past(mem_rdata)));

    p_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_op && op_code == 8'h79) |=>
            (x_sel == $past(p_sel) && t_out == $past({x_sel, p_sel})));

    p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_int_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_taken |=> (p_sel == 4'd1 && x_sel == 4'd2 && !ie_out
                       && t_out == $past({x_sel, p_sel})));

    p_int_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_out |-> !int_taken);
endmodule

bind ctx_regfile ctx_regfile_chk u_chk (.*);

// File: tb/tb_ctx_regfile.sv
module tb_ctx_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] d_in = 8'h00;
    logic       int_req = 1'b0;
    logic [7:0] mem_rdata = 8'h00;
    logic [7:0] d_out;
    logic       d_valid, int_taken, mem_we, mem_re, ie_out;
    logic [15:0] mem_addr, pc_out, dp_out;
    logic [7:0] mem_wdata, t_out;
    logic [3:0] p_sel, x_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Sampled combinational outputs, taken before the edge.
    logic [7:0]  s_d, s_wdata;
    logic [15:0] s_addr;
    logic        s_we, s_re, s_int;

    always #5 clk = ~clk;

    ctx_regfile dut (.*);

    // Vector: {op, d_in, mem_rdata, expected d_out, expected {x,p}, expected ie}
    localparam int NV = 34;
    localparam logic [40:0] VEC [NV] = '{
        {8'hA3, 8'h34, 8'h00, 8'h00, 8'h00, 1'b0},  // R2 low put
        {8'hB3, 8'h12, 8'h00, 8'h00, 8'h00, 1'b0},  // R2 high put
        {8'h83, 8'h00, 8'h00, 8'h34, 8'h00, 1'b0},  // R3 low get
        {8'h93, 8'h00, 8'h00, 8'h12, 8'h00, 1'b0},  // R3 high get
        {8'h13, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},  // R4 inc
        {8'h83, 8'h00, 8'h00, 8'h35, 8'h00, 1'b0},
        {8'hA4, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0},
        {8'hB4, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {8'h14, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},  // R4 carry into high byte
        {8'h84, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {8'h94, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0},
        {8'h24, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},  // R4 borrow
        {8'h84, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0},
        {8'h94, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {8'hB5, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {8'h25, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},  // R4 wrap 0000->FFFF
        {8'h85, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0},
        {8'h95, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0},
        {8'hE5, 8'h00, 8'h00, 8'h00, 8'h50, 1'b0},  // R5 data selector
        {8'h60, 8'h00, 8'h00, 8'h00, 8'h50, 1'b0},  // R6 FFFF->0000
        {8'h85, 8'h00, 8'h00, 8'h00, 8'h50, 1'b0},
        {8'hD3, 8'h00, 8'h00, 8'h00, 8'h53, 1'b0},  // R5 program selector
        {8'hA2, 8'h40, 8'h00, 8'h00, 8'h53, 1'b0},
        {8'hB2, 8'h00, 8'h00, 8'h00, 8'h53, 1'b0},
        {8'h79, 8'h00, 8'h00, 8'h00, 8'h33, 1'b0},  // R8 mark
        {8'h82, 8'h00, 8'h00, 8'h3F, 8'h33, 1'b0},  // R8 stack reg decremented
        {8'hF4, 8'h00, 8'h00, 8'h00, 8'h33, 1'b0},  // R13 other opcode
        {8'hAA, 8'h10, 8'h00, 8'h00, 8'h33, 1'b0},
        {8'hBA, 8'h00, 8'h00, 8'h00, 8'h33, 1'b0},
        {8'h70, 8'h00, 8'hA7, 8'h00, 8'hA7, 1'b1},  // R7 return
        {8'h83, 8'h00, 8'h00, 8'h36, 8'hA7, 1'b1},  // R7 old data reg advanced
        {8'h71, 8'h00, 8'h5C, 8'h00, 8'h5C, 1'b0},  // R7 disable
        {8'h8A, 8'h00, 8'h00, 8'h11, 8'h5C, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus; sample comb outputs before the edge,
    // state outputs just after it.
    task automatic step(input logic [7:0] op, input logic [7:0] din,
                        input logic [7:0] mrd, input logic irq, input logic v);
        op_code = op; d_in = din; mem_rdata = mrd; int_req = irq; op_valid = v;
        #1;
        s_d = d_out; s_addr = mem_addr; s_wdata = mem_wdata;
        s_we = mem_we; s_re = mem_re; s_int = int_taken;
        @(posedge clk);
        #1;
        op_valid = 1'b0; int_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk({x_sel, p_sel, ie_out, t_out} == 17'd0, "R1", {x_sel, p_sel, ie_out, t_out}, 0);
        step(8'h80, 8'h00, 8'h00, 1'b0, 1'b1);
        chk(s_d == 8'h00, "R1", s_d, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][40:33], VEC[i][32:25], VEC[i][24:17], 1'b0, 1'b1);
            chk(s_d == VEC[i][16:9], "R2/R3 d_out", s_d, VEC[i][16:9]);
            chk({x_sel, p_sel, ie_out} == {VEC[i][8:1], VEC[i][0]}, "R5/R7/R8 ctx",
                {x_sel, p_sel, ie_out}, {VEC[i][8:1], VEC[i][0]});
            if (VEC[i][40:33] == 8'hF4)
                chk(!s_we && !s_re, "R13 no strobe", {s_we, s_re}, 0);
        end

        // R9 save: X=5 (R5=0000), T=53
        step(8'h78, 8'h00, 8'h00, 1'b0, 1'b1);
        chk(s_we && s_addr == 16'h0000 && s_wdata == 8'h53, "R9",
            {s_we, s_addr, s_wdata}, {1'b1, 16'h0000, 8'h53});
        chk({x_sel, p_sel} == 8'h5C, "R9 ctx", {x_sel, p_sel}, 8'h5C);

        // R8 mark memory side: R2=003F, {x,p}=5C
        step(8'h79, 8'h00, 8'h00, 1'b0, 1'b1);
        chk(s_we && s_addr == 16'h003F && s_wdata == 8'h5C, "R8 mem",
            {s_we, s_addr, s_wdata}, {1'b1, 16'h003F, 8'h5C});
        chk(t_out == 8'h5C && {x_sel, p_sel} == 8'hCC, "R8 ctx", {t_out, x_sel, p_sel}, 16'h5CCC);

        // R7 read strobe: X=C, RC=0777
        step(8'hAC, 8'h77, 8'h00, 1'b0, 1'b1);
        step(8'hBC, 8'h07, 8'h00, 1'b0, 1'b1);
        step(8'h70, 8'h00, 8'h21, 1'b0, 1'b1);
        chk(s_re && !s_we && s_addr == 16'h0777, "R7 mem", {s_re, s_we, s_addr}, {2'b10, 16'h0777});
        chk({x_sel, p_sel, ie_out} == {8'h21, 1'b1}, "R7 ctx", {x_sel, p_sel, ie_out}, {8'h21, 1'b1});

        // R12 pc/dp views: P=1, X=2 (R2=003E)
        step(8'hA1, 8'h9A, 8'h00, 1'b0, 1'b1);
        step(8'hB1, 8'h00, 8'h00, 1'b0, 1'b1);
        chk(pc_out == 16'h009A && dp_out == 16'h003E, "R12", {pc_out, dp_out}, 32'h009A003E);

        // R10 interrupt beats INC R3
        step(8'hD4, 8'h00, 8'h00, 1'b0, 1'b1);
        step(8'h13, 8'h00, 8'h00, 1'b1, 1'b1);
        chk(s_int, "R10 taken", s_int, 1);
        chk({x_sel, p_sel, ie_out, t_out} == {8'h21, 1'b0, 8'h24}, "R10 ctx",
            {x_sel, p_sel, ie_out, t_out}, {8'h21, 1'b0, 8'h24});
        step(8'h83, 8'h00, 8'h00, 1'b0, 1'b1);
        chk(s_d == 8'h36, "R10 op dropped", s_d, 8'h36);

        // R11 masked request
        step(8'hD7, 8'h00, 8'h00, 1'b1, 1'b1);
        chk(!s_int, "R11 taken", s_int, 0);
        chk({x_sel, p_sel, t_out} == 16'h2724, "R11 ctx", {x_sel, p_sel, t_out}, 16'h2724);

        // R1 register 0 cleared by reset after a write
        step(8'hA0, 8'h55, 8'h00, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk({x_sel, p_sel, ie_out, t_out} == 17'd0, "R1 ctx", {x_sel, p_sel, ie_out, t_out}, 0);
        step(8'h80, 8'h00, 8'h00, 1'b0, 1'b1);
        chk(s_d == 8'h00, "R1 reg0", s_d, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule